// File: doc/BRIEF.md
# Framed 24-bit Serial Command Receiver

This block takes commands over a three-wire serial link (an active-low chip-select, a serial clock and a data line) and turns each completed 24-bit word into one write toward a 32-entry core store. Each write carries 16 bits of data and a 5-bit entry index. Bits are captured on rising serial-clock edges while chip-select is low, most significant first. One chip-select frame may carry any number of consecutive words, and each word is written as soon as its last bit arrives.

Every word also carries two mode bits. They are latched with the write and combined with two external mode pins, and a pin held high forces its mode on. A word's assembly runs entirely on the serial clock. The finished word crosses into the core clock through a toggle request that is synchronized in both directions. The assembled fields stay frozen in a holding register until the core side has taken them.

Top module: `fcmd_rx`

## Requirements
- R1: After reset, `wr_en` is low and both latched mode bits are zero, so `mode_immediate` equals `pin_immediate` and `mode_extclk` equals `pin_extclk`.
- R2: Serial bit 23 (the first bit after chip-select falls) is the data MSB. Bits 23..8 are the data, with bit 8 as the data LSB. Bits 7..3 are the entry index, with bit 3 as its LSB. Bit 2 is the immediate-mode bit, bit 1 is the external-clock bit and bit 0 is a fill bit.
- R3: Each completed 24-bit word produces exactly one `wr_en` pulse, one core clock long.
- R4: Several words sent in one chip-select frame are each written, in the order they were sent.
- R5: Bits of an unfinished word that remain when chip-select rises are discarded with no write. The bit position starts again at zero in the next frame and never exceeds 23.
- R6: `mode_immediate` is the immediate bit latched from the last written word ORed with `pin_immediate`.
- R7: `mode_extclk` is the external-clock bit latched from the last written word ORed with `pin_extclk`. A later word whose external-clock bit is 0 clears the latched bit.
- R8: The value of the fill bit has no effect on the written data, the entry index or the modes.
- R9: The latched mode bits change only in the cycle of a write. An unfinished word leaves them unchanged.
- R10: The holding register that feeds the core does not change while a request is still unacknowledged, so each write shows the fields of its own word even while later bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Frame select, active low |
| ser_clk | input | 1 | Serial clock, sampled on rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| pin_immediate | input | 1 | External force for immediate mode |
| pin_extclk | input | 1 | External force for external-clock mode |
| wr_en | output | 1 | One-cycle write strobe in the core domain |
| wr_addr | output | 5 | Entry index of the write |
| wr_data | output | 16 | Data of the write |
| mode_immediate | output | 1 | Effective immediate-mode flag |
| mode_extclk | output | 1 | Effective external-clock flag |

## Verification
The embedded assertions check four things on every cycle. The write strobe never lasts two cycles. The mode latch never moves without a write. The serial bit counter stays within a word. The holding register is frozen while a request is outstanding.

Only the bench scenarios can show that the bit order and field positions are right and that each word's fields reach the core unchanged. Those scenarios are a sweep over all 32 indices in a single frame, a sweep over every combination of mode bits and mode pins, and runs with truncated frames and a set fill bit.

// File: rtl/fcmd_pkg.sv
`timescale 1ns/1ps
package fcmd_pkg;
  parameter int DATA_W  = 16;
  parameter int ADDR_W  = 5;
  parameter int CTRL_W  = 2;
  parameter int FILL_W  = 1;
  parameter int WORD_W  = DATA_W + ADDR_W + CTRL_W + FILL_W;
  parameter int HOLD_W  = WORD_W - FILL_W;
  parameter int CNT_W   = $clog2(WORD_W);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              c_imm;
    logic              c_ext;
  } fcmd_fields_t;

  function automatic fcmd_fields_t fcmd_split(input logic [HOLD_W-1:0] w);
    fcmd_fields_t f;
    f.data  = w[HOLD_W-1 -: DATA_W];
    f.addr  = w[CTRL_W +: ADDR_W];
    f.c_imm = w[1];
    f.c_ext = w[0];
    return f;
  endfunction

  function automatic logic fcmd_last_bit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(WORD_W - 1);
  endfunction
endpackage

// File: rtl/fcmd_sync.sv
`timescale 1ns/1ps
module fcmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fcmd_serial_cap.sv
`timescale 1ns/1ps
module fcmd_serial_cap
  import fcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ack_tog,
  output logic              req_tog,
  output logic [HOLD_W-1:0] hold_q
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [HOLD_W-1:0] shreg;
  logic              ack_s;
  logic              pending;
  logic              word_done;

  fcmd_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(ser_clk), .rst_n(rst_n), .d(ack_tog), .q(ack_s)
  );

  assign pending   = req_tog ^ ack_s;
  assign word_done = fcmd_last_bit(bit_cnt);

  // bit position: held at zero whenever the frame is closed
  always_ff @(posedge ser_clk or posedge ser_cs_n) begin
    if (ser_cs_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      shreg <= {shreg[HOLD_W-2:0], ser_din};
      if (word_done) bit_cnt <= '0;
      else           bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  // last bit is the fill bit and is dropped here
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      req_tog <= 1'b0;
    end else if (!ser_cs_n && word_done && !pending) begin
      hold_q  <= shreg;
      req_tog <= ~req_tog;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge ser_clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(WORD_W)); // R5
  AST_HOLD_STABLE: assert property (@(posedge ser_clk) disable iff (!rst_n)
    $past(pending) |-> $stable(hold_q)); // R10
endmodule

// File: rtl/fcmd_core_if.sv
`timescale 1ns/1ps
module fcmd_core_if
  import fcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tog,
  input  logic [HOLD_W-1:0] hold_q,
  input  logic              pin_immediate,
  input  logic              pin_extclk,
  output logic              ack_tog,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mode_immediate,
  output logic              mode_extclk
);
  logic         req_s;
  logic         req_seen;
  logic         take_now;
  logic [1:0]   ctrl_q;
  fcmd_fields_t fields;

  fcmd_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tog), .q(req_s)
  );

  assign take_now = req_s ^ req_seen;
  assign fields   = fcmd_split(hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ctrl_q   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (take_now) begin
        req_seen <= req_s;
        wr_en    <= 1'b1;
        wr_addr  <= fields.addr;
        wr_data  <= fields.data;
        ctrl_q   <= {fields.c_imm, fields.c_ext};
      end
    end
  end

  assign ack_tog        = req_seen;
  assign mode_immediate = ctrl_q[1] | pin_immediate;
  assign mode_extclk    = ctrl_q[0] | pin_extclk;

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3
  AST_CTRL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> wr_en); // R9
endmodule

// File: rtl/fcmd_rx.sv
`timescale 1ns/1ps
module fcmd_rx
  import fcmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              pin_immediate,
  input  logic              pin_extclk,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mode_immediate,
  output logic              mode_extclk
);
  logic              req_tog;
  logic              ack_tog;
  logic [HOLD_W-1:0] hold_q;

  fcmd_serial_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ack_tog(ack_tog), .req_tog(req_tog), .hold_q(hold_q)
  );

  fcmd_core_if #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rst_n(rst_n), .req_tog(req_tog), .hold_q(hold_q),
    .pin_immediate(pin_immediate), .pin_extclk(pin_extclk),
    .ack_tog(ack_tog), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_immediate(mode_immediate), .mode_extclk(mode_extclk)
  );
endmodule

// File: tb/sim_fcmd_rx.sv
`timescale 1ns/1ps
module sim_fcmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic p_imm = 1'b0, p_ext = 1'b0;
  logic wr_en, m_imm, m_ext;
  logic [4:0] wr_addr;
  logic [15:0] wr_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0]  exp_a [0:63];
  logic [15:0] exp_d [0:63];
  logic [4:0]  obs_a [0:63];
  logic [15:0] obs_d [0:63];
  int exp_n = 0, obs_n = 0;

  always #10 clk = ~clk;

  fcmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sclk), .ser_din(din),
    .pin_immediate(p_imm), .pin_extclk(p_ext), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_immediate(m_imm), .mode_extclk(m_ext)
  );

  always @(negedge clk) begin
    if (wr_en && obs_n < 64) begin
      obs_a[obs_n] = wr_addr;
      obs_d[obs_n] = wr_data;
      obs_n = obs_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total = total + 1;
    if (act !== expv) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put_bits(input logic [23:0] w, input int n);
    for (int i = 23; i > 23 - n; i--) begin
      din = w[i];
      #80 sclk = 1'b1;
      #80 sclk = 1'b0;
    end
  endtask

  task automatic put_word(input logic [15:0] d, input logic [4:0] a,
                          input logic ci, input logic ce, input logic f);
    put_bits({d, a, ci, ce, f}, 24);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n = exp_n + 1;
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    #50;
  endtask

  task automatic close_frame();
    #50 cs_n = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check({req, " write count"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      check({req, " addr"}, obs_a[i], exp_a[i]);
      check({req, " data"}, obs_d[i], exp_d[i]);
    end
    obs_n = 0;
    exp_n = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 wr_en", wr_en, 0);
    check("R1 imm", m_imm, 0);
    check("R1 ext", m_ext, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    p_imm = 1; p_ext = 1; #1;
    check("R1 imm pin", m_imm, 1);
    check("R1 ext pin", m_ext, 1);
    p_imm = 0; p_ext = 0;

    // R2 R3 R4 R10: all 32 entries in one frame, back to back
    open_frame();
    for (int k = 0; k < 32; k++)
      put_word(16'((k * 16'h0813) ^ 16'hA5C3), 5'(31 - k), 1'b0, 1'b0, 1'b0);
    close_frame();
    compare("R4 R10 sweep");

    // R2: single-bit walk across the data field
    open_frame();
    for (int b = 0; b < 16; b++) put_word(16'(1 << b), 5'(b), 1'b0, 1'b0, 1'b0);
    close_frame();
    compare("R2 walk");

    // R6 R7: every mode bit pair against every pin pair
    for (int c = 0; c < 4; c++) begin
      open_frame();
      put_word(16'(c), 5'(c), c[1], c[0], 1'b0);
      close_frame();
      compare("R3 mode word");
      for (int p = 0; p < 4; p++) begin
        p_imm = p[1]; p_ext = p[0]; #1;
        check("R6 imm", m_imm, c[1] | p[1]);
        check("R7 ext", m_ext, c[0] | p[0]);
      end
      p_imm = 0; p_ext = 0;
    end

    // R9 R5: truncated word with other mode bits changes nothing
    open_frame();
    put_bits({16'h1234, 5'd9, 1'b0, 1'b0, 1'b0}, 23);
    close_frame();
    check("R5 no write", obs_n, 0);
    #1;
    check("R9 imm kept", m_imm, 1);
    check("R9 ext kept", m_ext, 1);

    // R5: short prefix then a full word in the next frame
    open_frame();
    put_bits(24'hFFFFFF, 10);
    close_frame();
    open_frame();
    put_word(16'h5A0F, 5'd17, 1'b0, 1'b1, 1'b0);
    close_frame();
    compare("R5 restart");
    #1;
    check("R7 ext relatch", m_ext, 1);
    check("R6 imm cleared", m_imm, 0);

    // R8: fill bit set
    open_frame();
    put_word(16'hC3E1, 5'd22, 1'b1, 1'b0, 1'b1);
    close_frame();
    compare("R8 fill");
    #1;
    check("R8 imm", m_imm, 1);
    check("R8 ext", m_ext, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule